// File: doc/BRIEF.md
# Phase-Qualified Address Decoder and Bus Strobe Generator

This block is the glue logic between an 8-bit processor with a single read/write line and its memory and I/O devices. It looks at the four most significant address bits and pulls low exactly one of four chip selects: system RAM, the program ROM, a dual UART and a parallel I/O timer device. The chip selects depend on the address alone.

It also turns the processor's read/write line into separate active-low read and write strobes. These are only allowed while the phase-2 clock is high, and they drive devices that have distinct read-enable and write-enable pins. The ROM output enable comes from the read strobe, so the ROM drives the data bus only during phase 2 of a read cycle. The parallel I/O device is wired to the raw read/write line and receives only its chip select from this block.

The logic is purely combinational and holds no state. Any change on an input appears on the outputs in the same cycle.

Top module: `glue_decode`

## Requirements
- R1: `rd_n` is 0 exactly when `phi2` is 1 and `rwb` is 1; otherwise it is 1.
- R2: `wr_n` is 0 exactly when `phi2` is 1 and `rwb` is 0; otherwise it is 1.
- R3: While `phi2` is 0, both `rd_n` and `wr_n` are 1 whatever the values of `rwb` and `addr_hi`.
- R4: `uart_cs_n` is 0 exactly when `addr_hi` equals 4'b0101 (addresses $5000-$5FFF).
- R5: `ram_cs_n` is 0 exactly when `addr_hi` is in the range 4'h0 to 4'h4 (addresses $0000-$4FFF).
- R6: `pio_cs_n` is 0 exactly when `addr_hi` equals 4'h6 (addresses $6000-$6FFF).
- R7: `rom_cs_n` is 0 exactly when `addr_hi` is 4'h8 or higher, i.e. bit 3 is set (addresses $8000-$FFFF).
- R8: At most one chip select is 0 at any time. When `addr_hi` is 4'h7, all four chip selects are 1.
- R9: The chip selects do not depend on `phi2` or `rwb`. The same `addr_hi` gives the same chip-select pattern in all four combinations of those two inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-2 clock from the processor; high during the data phase |
| rwb | input | 1 | Processor read/write line, 1 = read, 0 = write |
| addr_hi | input | 4 | Address bits 15 down to 12 |
| ram_cs_n | output | 1 | RAM chip select, active low |
| uart_cs_n | output | 1 | Dual UART chip select, active low |
| pio_cs_n | output | 1 | Parallel I/O device chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rd_n | output | 1 | Read strobe qualified by phase 2, active low |
| wr_n | output | 1 | Write strobe qualified by phase 2, active low |

## Verification
The checker treats every input as a settled two-state level and assumes it is sampled only after a change has propagated through the combinational paths. It also assumes the address map regions never overlap. The bench meets these conditions by changing `phi2`, `rwb` and `addr_hi` together on one clock edge and sampling the outputs a short fixed delay later, long before the next change. The bench sweeps all sixteen address nibbles under every combination of `phi2` and `rwb`. This covers the unmapped nibble and the boundaries at 4 to 5, 6 to 7 and 7 to 8.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int HI_W    = 4;
    localparam int NUM_DEV = 4;

    typedef enum logic [1:0] {
        DEV_RAM  = 2'd0,
        DEV_UART = 2'd1,
        DEV_PIO  = 2'd2,
        DEV_ROM  = 2'd3
    } dev_e;

    // Inclusive nibble range of each device, indexed by dev_e
    localparam logic [HI_W-1:0] DEV_LO [NUM_DEV] = '{4'h0, 4'h5, 4'h6, 4'h8};
    localparam logic [HI_W-1:0] DEV_HI [NUM_DEV] = '{4'h4, 4'h5, 4'h6, 4'hF};

    typedef struct packed {
        logic [NUM_DEV-1:0] cs_n;
        logic               rd_n;
        logic               wr_n;
    } glue_out_t;
endpackage

// File: rtl/glue_range_match.sv
module glue_range_match #(
    parameter int              W  = 4,
    parameter logic [W-1:0]    LO = '0,
    parameter logic [W-1:0]    HI = '1
) (
    input  logic [W-1:0] addr,
    output logic         hit
);
    always_comb begin
        hit = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen (
    input  logic phi2,
    input  logic rwb,
    output logic rd_n,
    output logic wr_n
);
    logic rd_act;
    logic wr_act;
    always_comb begin
        rd_act = phi2 & rwb;
        wr_act = phi2 & ~rwb;
        rd_n   = ~rd_act;
        wr_n   = ~wr_act;
    end
endmodule

// File: rtl/glue_decode.sv
module glue_decode
    import glue_pkg::*;
(
    input  logic            phi2,
    input  logic            rwb,
    input  logic [HI_W-1:0] addr_hi,
    output logic            ram_cs_n,
    output logic            uart_cs_n,
    output logic            pio_cs_n,
    output logic            rom_cs_n,
    output logic            rd_n,
    output logic            wr_n
);
    logic [NUM_DEV-1:0] hit;
    logic               strb_rd_n;
    logic               strb_wr_n;
    glue_out_t          out_d;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_region
        glue_range_match #(
            .W  (HI_W),
            .LO (DEV_LO[g]),
            .HI (DEV_HI[g])
        ) u_match (
            .addr (addr_hi),
            .hit  (hit[g])
        );
    end

    glue_strobe_gen u_strobe (
        .phi2 (phi2),
        .rwb  (rwb),
        .rd_n (strb_rd_n),
        .wr_n (strb_wr_n)
    );

    always_comb begin
        out_d      = '0;
        out_d.cs_n = ~hit;
        out_d.rd_n = strb_rd_n;
        out_d.wr_n = strb_wr_n;
    end

    assign ram_cs_n  = out_d.cs_n[DEV_RAM];
    assign uart_cs_n = out_d.cs_n[DEV_UART];
    assign pio_cs_n  = out_d.cs_n[DEV_PIO];
    assign rom_cs_n  = out_d.cs_n[DEV_ROM];
    assign rd_n      = out_d.rd_n;
    assign wr_n      = out_d.wr_n;
endmodule

// File: rtl/glue_decode_checker.sv
module glue_decode_checker (
    input logic       phi2,
    input logic       rwb,
    input logic [3:0] addr_hi,
    input logic       ram_cs_n,
    input logic       uart_cs_n,
    input logic       pio_cs_n,
    input logic       rom_cs_n,
    input logic       rd_n,
    input logic       wr_n
);
    always_comb begin
        if (!rd_n) AST_RD_NEEDS_READ_PHASE: assert (phi2 && rwb); // R1
        if (!wr_n) AST_WR_NEEDS_WRITE_PHASE: assert (phi2 && !rwb); // R2
        if (!phi2) AST_IDLE_STROBES_HIGH: assert (rd_n && wr_n); // R3
        if (!uart_cs_n) AST_UART_WINDOW: assert (addr_hi == 4'h5); // R4
        if (!pio_cs_n) AST_PIO_WINDOW: assert (addr_hi == 4'h6); // R6
        if (!rom_cs_n) AST_ROM_UPPER_HALF: assert (addr_hi[3]); // R7
        AST_ONE_SELECT: assert ($countones({ram_cs_n, uart_cs_n, pio_cs_n, rom_cs_n}) >= 3); // R8
        if (addr_hi == 4'h7) AST_HOLE_UNSELECTED: assert (ram_cs_n && uart_cs_n && pio_cs_n && rom_cs_n); // R8
    end
endmodule

bind glue_decode glue_decode_checker u_chk (
    .phi2      (phi2),
    .rwb       (rwb),
    .addr_hi   (addr_hi),
    .ram_cs_n  (ram_cs_n),
    .uart_cs_n (uart_cs_n),
    .pio_cs_n  (pio_cs_n),
    .rom_cs_n  (rom_cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/glue_decode_bench.sv
`timescale 1ns/1ps
module glue_decode_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phi2 = 1'b0;
    logic       rwb = 1'b1;
    logic [3:0] addr_hi = 4'h0;
    logic       ram_cs_n, uart_cs_n, pio_cs_n, rom_cs_n, rd_n, wr_n;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    glue_decode u_glue_decode (
        .phi2      (phi2),
        .rwb       (rwb),
        .addr_hi   (addr_hi),
        .ram_cs_n  (ram_cs_n),
        .uart_cs_n (uart_cs_n),
        .pio_cs_n  (pio_cs_n),
        .rom_cs_n  (rom_cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );

    // Expected chip-select pattern {rom, pio, uart, ram}, active low, from the address map
    function automatic logic [3:0] exp_cs(input logic [3:0] a);
        logic [3:0] v = 4'b1111;
        if (a <= 4'h4) v[0] = 1'b0;
        if (a == 4'h5) v[1] = 1'b0;
        if (a == 4'h6) v[2] = 1'b0;
        if (a[3])      v[3] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h phi2=%b rwb=%b actual=%b expected=%b",
                     req, addr_hi, phi2, rwb, act, exp);
        end
    endtask

    task automatic apply(input logic p, input logic r, input logic [3:0] a);
        @(negedge clk);
        phi2 = p; rwb = r; addr_hi = a;
        #2;
    endtask

    function automatic logic [3:0] cs_now();
        return {rom_cs_n, pio_cs_n, uart_cs_n, ram_cs_n};
    endfunction

    // Outputs right after reset with phase 1 idle
    task automatic t_reset_idle();
        apply(1'b0, 1'b1, 4'h0);
        chk("R3", {2'b00, rd_n, wr_n}, 4'b0011);
        chk("R5", cs_now(), 4'b1110);
    endtask

    // Phase 2 read across every nibble
    task automatic t_read_sweep();
        for (int a = 0; a < 16; a++) begin
            apply(1'b1, 1'b1, 4'(a));
            chk("R1", {2'b00, rd_n, wr_n}, 4'b0001);
            chk("R4_R5_R6_R7", cs_now(), exp_cs(4'(a)));
        end
    endtask

    // Phase 2 write across every nibble
    task automatic t_write_sweep();
        for (int a = 0; a < 16; a++) begin
            apply(1'b1, 1'b0, 4'(a));
            chk("R2", {2'b00, rd_n, wr_n}, 4'b0010);
            chk("R4_R5_R6_R7", cs_now(), exp_cs(4'(a)));
        end
    endtask

    // Phase 1 with both directions: strobes stay high
    task automatic t_phase1_sweep();
        for (int r = 0; r < 2; r++) begin
            for (int a = 0; a < 16; a++) begin
                apply(1'b0, r[0], 4'(a));
                chk("R3", {2'b00, rd_n, wr_n}, 4'b0011);
                chk("R9", cs_now(), exp_cs(4'(a)));
            end
        end
    endtask

    // Unmapped nibble and region boundaries
    task automatic t_boundaries();
        apply(1'b1, 1'b1, 4'h7);
        chk("R8", cs_now(), 4'b1111);
        apply(1'b1, 1'b1, 4'h4);
        chk("R5", cs_now(), 4'b1110);
        apply(1'b1, 1'b1, 4'h5);
        chk("R4", cs_now(), 4'b1101);
        apply(1'b1, 1'b0, 4'h6);
        chk("R6", cs_now(), 4'b1011);
        apply(1'b0, 1'b0, 4'h8);
        chk("R7", cs_now(), 4'b0111);
    endtask

    // At most one select low, and the same pattern in every strobe state
    task automatic t_exclusive();
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 4; s++) begin
                apply(s[1], s[0], 4'(a));
                chk("R8", {3'b000, ($countones(cs_now()) < 3)}, 4'b0000);
                chk("R9", cs_now(), exp_cs(4'(a)));
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_read_sweep();
        t_write_sweep();
        t_phase1_sweep();
        t_boundaries();
        t_exclusive();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule